// File: doc/BRIEF.md
# DDR region security filter

This block decides, in the same cycle, whether an access to DDR memory may proceed. Each access presents a byte address and a secure/non-secure attribute. The block answers allow or deny from eight programmable address windows, one catch-all window for the rest of memory, and one global bypass. Secure accesses always pass. A non-secure access is refused when it lands inside a protected window.

Each window is given by a start and an end in 1 MB units, and the end is inclusive. The start values sit at register indices 0 to 7 and the ends at indices 8 to 15, so window n uses indices n and n+8. Index 16 is the control word. Software writes the registers through a single 32-bit write port. The upper half of each written word is a per-bit write enable for the lower half, so one bit can change without a read-modify-write. Bus bridging, error replies and interrupts belong to the surrounding fabric.

Top module: `memsec_filter`

## Requirements
- R1: After reset every register reads as zero, so every access, secure or not, is allowed.
- R2: A write carries data in bits 15:0 and per-bit enables in bits 31:16. A register bit takes the new data bit only when its enable bit is 1. Otherwise it keeps its old value.
- R3: An address is inside window n when its megabyte index (address bits 31:20), zero-extended to 16 bits, is at least start[n] and at most end[n]. Both bounds are included, so start 0 with end 0 covers 0x0 to 0xFFFFF.
- R4: Control bits 7:0 enable protection for windows 0 to 7 (1 = enabled). When bypass is 0, a non-secure access inside an enabled window is denied. A window whose bit is 0 causes no denial.
- R5: Control bit 8 protects the rest of memory. When it is 1 and bypass is 0, a non-secure access outside the bounds of all eight windows is denied. A window's bounds count for this test whether its enable bit is set or not.
- R6: Control bit 9 is a global bypass. When it is 1, every access is allowed.
- R7: A secure access (chk_secure = 1) is always allowed.
- R8: Windows may overlap. If any enabled window contains the address, the access is denied. There is no priority between windows.
- R9: A write to a register index above 16 changes no register.
- R10: The decision is combinational from the access inputs. A register write takes effect from the clock edge that captures it, and the decision made before that edge still uses the old value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_idx | input | 5 | Register index of the write (0 to 16 valid) |
| wr_word | input | 32 | Bits 31:16 per-bit enable, bits 15:0 data |
| chk_addr | input | 32 | Byte address of the access being checked |
| chk_secure | input | 1 | 1 = secure access, 0 = non-secure |
| chk_allow | output | 1 | 1 = access allowed, 0 = denied |

## Verification
The bench builds the block with its default parameters: eight windows, 32-bit addresses and a 1 MB grain. The 5-bit write index therefore also reaches the unused indices 17 to 31. Random bounds are kept below 64 MB, so random addresses often land on window edges, inside overlapping windows, and inside disabled windows that still shadow the rest-of-memory bit. Random full-range addresses reach the catch-all region.

// File: rtl/memsec_pkg.sv
package memsec_pkg;

    localparam int REG_W  = 16;
    localparam int WORD_W = 2 * REG_W;

    typedef logic [REG_W-1:0] reg_word_t;

    typedef struct packed {
        logic bypass;
        logic rest_en;
    } glob_cfg_t;

    typedef enum logic {
        VERDICT_DENY  = 1'b0,
        VERDICT_ALLOW = 1'b1
    } verdict_e;

    // Masked merge: upper half selects which lower-half bits land.
    function automatic reg_word_t masked_update(input reg_word_t old_val,
                                                input logic [WORD_W-1:0] wr);
        reg_word_t sel;
        sel = wr[WORD_W-1:REG_W];
        return (old_val & ~sel) | (wr[REG_W-1:0] & sel);
    endfunction

endpackage

// File: rtl/memsec_regs.sv
module memsec_regs
    import memsec_pkg::*;
#(
    parameter int NREG  = 17,
    parameter int IDX_W = 5
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         wr_en,
    input  logic [IDX_W-1:0]             wr_idx,
    input  logic [WORD_W-1:0]            wr_word,
    output logic [NREG-1:0][REG_W-1:0]   regs_q
);

    logic idx_ok;
    assign idx_ok = (int'(wr_idx) < NREG);

    always_ff @(posedge clk) begin
        if (rst) begin
            regs_q <= '0;
        end else if (wr_en && idx_ok) begin
            regs_q[wr_idx] <= masked_update(regs_q[wr_idx], wr_word);
        end
    end

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (regs_q == '0));

    // R2
    masked_bits_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && idx_ok) |=>
        ((regs_q[$past(wr_idx)] & ~$past(wr_word[WORD_W-1:REG_W])) ==
         ($past(regs_q[wr_idx]) & ~$past(wr_word[WORD_W-1:REG_W]))));

    // R9
    bad_index_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !idx_ok) |=> $stable(regs_q));

endmodule

// File: rtl/memsec_match.sv
module memsec_match
    import memsec_pkg::*;
#(
    parameter int NUM_RGN = 8
) (
    input  logic [REG_W-1:0]                 mb_idx,
    input  logic [NUM_RGN-1:0][REG_W-1:0]    starts,
    input  logic [NUM_RGN-1:0][REG_W-1:0]    ends,
    output logic [NUM_RGN-1:0]               in_rgn
);

    for (genvar g = 0; g < NUM_RGN; g++) begin : g_cmp
        assign in_rgn[g] = (mb_idx >= starts[g]) && (mb_idx <= ends[g]);
    end

endmodule

// File: rtl/memsec_decide.sv
module memsec_decide
    import memsec_pkg::*;
#(
    parameter int NUM_RGN = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NUM_RGN-1:0]   in_rgn,
    input  logic [REG_W-1:0]     ctrl,
    input  logic                 chk_secure,
    output verdict_e             verdict
);

    localparam int REST_BIT   = NUM_RGN;
    localparam int BYPASS_BIT = NUM_RGN + 1;

    glob_cfg_t           glob;
    logic [NUM_RGN-1:0]  rgn_en;
    logic                en_hit;
    logic                outside_all;
    logic                deny;

    assign glob.bypass  = ctrl[BYPASS_BIT];
    assign glob.rest_en = ctrl[REST_BIT];
    assign rgn_en       = ctrl[NUM_RGN-1:0];

    always_comb begin
        en_hit      = |(in_rgn & rgn_en);
        outside_all = (in_rgn == '0);
        deny        = !chk_secure && !glob.bypass &&
                      (en_hit || (glob.rest_en && outside_all));
        verdict     = deny ? VERDICT_DENY : VERDICT_ALLOW;
    end

    // R7
    secure_open_chk: assert property (@(posedge clk) disable iff (rst)
        chk_secure |-> (verdict == VERDICT_ALLOW));

    // R6
    bypass_open_chk: assert property (@(posedge clk) disable iff (rst)
        ctrl[BYPASS_BIT] |-> (verdict == VERDICT_ALLOW));

    // R4
    enabled_hit_deny_chk: assert property (@(posedge clk) disable iff (rst)
        (!chk_secure && !ctrl[BYPASS_BIT] && ((in_rgn & ctrl[NUM_RGN-1:0]) != '0))
        |-> (verdict == VERDICT_DENY));

    // R5
    rest_deny_chk: assert property (@(posedge clk) disable iff (rst)
        (!chk_secure && !ctrl[BYPASS_BIT] && ctrl[REST_BIT] && $countones(in_rgn) == 0)
        |-> (verdict == VERDICT_DENY));

endmodule

// File: rtl/memsec_filter.sv
module memsec_filter
    import memsec_pkg::*;
#(
    parameter int NUM_RGN   = 8,
    parameter int ADDR_W    = 32,
    parameter int GRAIN_LSB = 20,
    localparam int NREG     = 2 * NUM_RGN + 1,
    localparam int IDX_W    = $clog2(NREG),
    localparam int MB_W     = ADDR_W - GRAIN_LSB
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_en,
    input  logic [IDX_W-1:0]    wr_idx,
    input  logic [WORD_W-1:0]   wr_word,
    input  logic [ADDR_W-1:0]   chk_addr,
    input  logic                chk_secure,
    output logic                chk_allow
);

    logic [NREG-1:0][REG_W-1:0]     regs_q;
    logic [NUM_RGN-1:0][REG_W-1:0]  starts;
    logic [NUM_RGN-1:0][REG_W-1:0]  ends;
    logic [REG_W-1:0]               ctrl;
    logic [REG_W-1:0]               mb_idx;
    logic [NUM_RGN-1:0]             in_rgn;
    verdict_e                       verdict;

    memsec_regs #(.NREG(NREG), .IDX_W(IDX_W)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .wr_word (wr_word),
        .regs_q  (regs_q)
    );

    for (genvar g = 0; g < NUM_RGN; g++) begin : g_bank
        assign starts[g] = regs_q[g];
        assign ends[g]   = regs_q[g + NUM_RGN];
    end

    assign ctrl   = regs_q[2 * NUM_RGN];
    assign mb_idx = REG_W'(chk_addr[ADDR_W-1:GRAIN_LSB]);

    memsec_match #(.NUM_RGN(NUM_RGN)) u_match (
        .mb_idx (mb_idx),
        .starts (starts),
        .ends   (ends),
        .in_rgn (in_rgn)
    );

    memsec_decide #(.NUM_RGN(NUM_RGN)) u_decide (
        .clk        (clk),
        .rst        (rst),
        .in_rgn     (in_rgn),
        .ctrl       (ctrl),
        .chk_secure (chk_secure),
        .verdict    (verdict)
    );

    assign chk_allow = (verdict == VERDICT_ALLOW);

endmodule

// File: tb/memsec_filter_test.sv
module memsec_filter_test;

    localparam int CLK_PERIOD = 10;
    localparam int WD_LIMIT   = 100000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [4:0]  wr_idx = '0;
    logic [31:0] wr_word = '0;
    logic [31:0] chk_addr = '0;
    logic        chk_secure = 1'b0;
    logic        chk_allow;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    logic [15:0] m [17];

    memsec_filter uut (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (wr_en),
        .wr_idx     (wr_idx),
        .wr_word    (wr_word),
        .chk_addr   (chk_addr),
        .chk_secure (chk_secure),
        .chk_allow  (chk_allow)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    always @(posedge clk) begin
        cyc++;
        if (cyc > WD_LIMIT) begin
            errors++;
            $display("FAIL watchdog expired actual=%0d expected<=%0d", cyc, WD_LIMIT);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    function automatic logic exp_allow(input logic [31:0] a, input logic s);
        logic [15:0] mb;
        logic any_in, en_hit, deny;
        mb = {4'b0, a[31:20]};
        any_in = 1'b0;
        en_hit = 1'b0;
        for (int i = 0; i < 8; i++) begin
            if (mb >= m[i] && mb <= m[i + 8]) begin
                any_in = 1'b1;
                if (m[16][i]) en_hit = 1'b1;
            end
        end
        deny = !s && !m[16][9] && (en_hit || (m[16][8] && !any_in));
        return !deny;
    endfunction

    task automatic check(input logic [31:0] a, input logic s, input string tag);
        logic e;
        chk_addr = a;
        chk_secure = s;
        #1;
        e = exp_allow(a, s);
        checks++;
        if (chk_allow !== e) begin
            errors++;
            $display("FAIL %s addr=%h sec=%0d actual=%0d expected=%0d",
                     tag, a, s, chk_allow, e);
        end
    endtask

    task automatic model_write(input logic [4:0] idx, input logic [31:0] w);
        if (idx < 17) m[idx] = (m[idx] & ~w[31:16]) | (w[15:0] & w[31:16]);
    endtask

    task automatic do_write(input logic [4:0] idx, input logic [31:0] w);
        @(negedge clk);
        wr_en = 1'b1;
        wr_idx = idx;
        wr_word = w;
        @(negedge clk);
        wr_en = 1'b0;
        model_write(idx, w);
    endtask

    initial begin
        void'($urandom(1234));
        for (int i = 0; i < 17; i++) m[i] = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: reset state leaves everything open
        check(32'h0000_0000, 1'b0, "R1");
        check(32'h1234_5678, 1'b0, "R1");
        check(32'hFFFF_FFFF, 1'b0, "R1");

        // R10: enable window 0 (bounds 0..0); old decision holds before the edge
        @(negedge clk);
        wr_en = 1'b1; wr_idx = 5'd16; wr_word = 32'h0001_0001;
        check(32'h0000_0000, 1'b0, "R10 before edge");
        @(negedge clk);
        wr_en = 1'b0;
        model_write(5'd16, 32'h0001_0001);
        check(32'h0000_0000, 1'b0, "R10 after edge");
        // R3: inclusive single-MB window
        check(32'h000F_FFFF, 1'b0, "R3");
        check(32'h0010_0000, 1'b0, "R3");
        // R7
        check(32'h0000_0000, 1'b1, "R7");

        // window 1 covers MB 2..31
        do_write(5'd1, 32'hFFFF_0002);
        do_write(5'd9, 32'hFFFF_001F);
        // R2: set only bit 1; bit 0 must stay set
        do_write(5'd16, 32'h0002_FFFF);
        check(32'h0000_0000, 1'b0, "R2");
        check(32'h01F0_0000, 1'b0, "R4");
        check(32'h0200_0000, 1'b0, "R3");
        check(32'h0010_0000, 1'b0, "R3");
        // R2: clear only bit 0
        do_write(5'd16, 32'h0001_0000);
        check(32'h0000_0000, 1'b0, "R2");
        check(32'h01F0_0000, 1'b0, "R2");

        // R8: window 2 covers MB 10..40, disabled first
        do_write(5'd2, 32'hFFFF_000A);
        do_write(5'd10, 32'hFFFF_0028);
        check(32'h0200_0000, 1'b0, "R4 disabled");
        check(32'h0140_0000, 1'b0, "R8");
        do_write(5'd16, 32'h0004_0004);
        check(32'h0200_0000, 1'b0, "R8");
        check(32'h0140_0000, 1'b0, "R8");

        // R5: rest-of-memory; disabled window 0 bounds still shadow MB 0
        do_write(5'd16, 32'h0100_0100);
        check(32'h8000_0000, 1'b0, "R5");
        check(32'h0000_0000, 1'b0, "R5");
        check(32'h8000_0000, 1'b1, "R7");

        // R6: bypass
        do_write(5'd16, 32'h0200_0200);
        check(32'h8000_0000, 1'b0, "R6");
        check(32'h0140_0000, 1'b0, "R6");
        do_write(5'd16, 32'h0200_0000);

        // R9: out-of-range indices
        do_write(5'd17, 32'hFFFF_FFFF);
        do_write(5'd31, 32'hFFFF_0000);
        check(32'h8000_0000, 1'b0, "R9");
        check(32'h0000_0000, 1'b0, "R9");
        check(32'h0140_0000, 1'b0, "R9");

        // random mix
        for (int it = 0; it < 400; it++) begin
            logic [4:0]  idx;
            logic [31:0] w;
            idx = 5'($urandom % 20);
            if (idx < 16) begin
                w = {16'($urandom), 16'($urandom % 64)};
            end else begin
                w = {16'($urandom), 16'($urandom)};
                if (($urandom % 4) != 0) w[9] = 1'b0;
            end
            do_write(idx, w);
            for (int k = 0; k < 4; k++) begin
                logic [31:0] a;
                if (($urandom % 4) == 0) a = $urandom;
                else a = {6'd0, 6'($urandom % 64), 20'($urandom)};
                check(a, 1'($urandom % 5 == 0), "R3 R4 R5 R8 random");
            end
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule